// File: doc/BRIEF.md
# System Bus Access Engine

This block is a debug-side bus master that performs one memory read or write at a time on a simple request/response bus. Debug logic loads a control word, an address spread over four 32-bit words and up to two 32-bit data words through a small register port. It then pulses a command input that selects a read or a write. The engine raises a bus request of 8, 16, 32 or 64 bits and places the data on the byte lanes that the low address bits select. It then waits for the response.

On a good response a read lands in the data words, and the address may step forward by the access size. The step carries across all four address words, so a 128-bit address is possible even though only the lower 64 bits reach the bus. A bus fault or an unsupported size code is recorded in a sticky error field. While that field is nonzero, every further command is refused until software clears the field.

Top module: `sba_engine`

## Requirements
- R1: Size code c in control bits [2:0], for c from 0 to 3, gives a request of 2^c bytes. `req_size` equals c. `req_strb` has 2^c set bits, starting at byte lane `off`, where `off` is address bits [2:0] with their low c bits cleared.
- R2: A command with size code 4 to 7 raises no request and sets the error field (control bits [6:4]) to 3.
- R3: A response with `resp_fault` set makes the error field 2. The data words and the address words are left unchanged.
- R4: While the error field is nonzero, commands raise no request. Writing the control register clears each error bit whose matching bit in `reg_wdata[6:4]` is 1. Other error bits stay set.
- R5: With autoincrement on (control bit 3), a good response adds 2^c to the address. With autoincrement off, or after a fault, the address is unchanged.
- R6: The autoincrement addition spans address words 0 to 3 (register indices 1 to 4). The carry out of each word goes into the next higher word.
- R7: `req_addr` is address word 1 in bits [63:32] and address word 0 in bits [31:0].
- R8: A 64-bit read writes bus bits [31:0] to data word 0 (index 5) and bits [63:32] to data word 1 (index 6). A narrower read takes its bytes from lane `off` and zero-extends them into data word 0. Data word 1 is left unchanged.
- R9: A 64-bit write sends {data word 1, data word 0}. A narrower write sends the low 2^c bytes of data word 0, shifted to lane `off`.
- R10: Control bit 7 reads 1 from the cycle after a command is accepted until the cycle after its response. During that time, register writes are ignored and `req_valid`, `req_addr` and `req_wdata` do not change.
- R11: After reset, every register reads 0 and `req_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Write index: 0 control, 1-4 address words, 5-6 data words |
| reg_wdata | input | 32 | Register write data |
| rd_idx | input | 3 | Read index, same map as `reg_idx` |
| rd_data | output | 32 | Register read data (combinational) |
| cmd_valid | input | 1 | Start an access |
| cmd_write | input | 1 | 1 for write, 0 for read |
| req_valid | output | 1 | Bus request pending |
| req_write | output | 1 | Request direction |
| req_size | output | 2 | Size code of the request |
| req_addr | output | 64 | Byte address |
| req_wdata | output | 64 | Lane-steered write data |
| req_strb | output | 8 | Byte enables |
| resp_valid | input | 1 | One-cycle response |
| resp_fault | input | 1 | Response reports an access fault |
| resp_rdata | input | 64 | Lane-aligned read data |

## Verification
A wrong lane offset or a wrong size decode appears on `req_strb` and `req_wdata` in the first cycle of the request. After a read it also appears as wrong bytes in the data words. A bad increment or a broken carry shows in the address words one cycle after the response. Sweeping every size and aligned offset against a bench byte memory, and later reading back 64-bit words, catches a write that was steered wrongly even when the request itself looked correct. If the error state is wrong, the effect is visible on the next command: either a request is raised that should not be, or a request is missing.

// File: rtl/sba_pkg.sv
package sba_pkg;

    localparam int SBA_WORD_W     = 32;
    localparam int SBA_ADDR_WORDS = 4;
    localparam int SBA_BUS_W      = 2 * SBA_WORD_W;
    localparam int SBA_STRB_W     = SBA_BUS_W / 8;
    localparam int SBA_OFF_W      = $clog2(SBA_STRB_W);
    localparam int SBA_IDX_W      = 3;
    localparam int SBA_STEP_W     = SBA_OFF_W + 1;

    localparam logic [SBA_IDX_W-1:0] IDX_CTRL      = 3'd0;
    localparam int                   IDX_ADDR_BASE = 1;
    localparam int                   IDX_DATA_BASE = IDX_ADDR_BASE + SBA_ADDR_WORDS;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_BUS  = 3'd2;
    localparam logic [2:0] ERR_SIZE = 3'd3;

    typedef struct packed {
        logic [2:0] err;
        logic       autoinc;
        logic [2:0] size;
    } ctrl_t;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_t;

    function automatic logic [SBA_STEP_W-1:0] size_bytes(input logic [1:0] code);
        return SBA_STEP_W'(1) << code;
    endfunction

    function automatic logic [SBA_OFF_W-1:0] lane_off(input logic [SBA_OFF_W-1:0] a,
                                                       input logic [1:0] code);
        logic [SBA_OFF_W-1:0] low;
        low = SBA_OFF_W'(size_bytes(code) - SBA_STEP_W'(1));
        return a & ~low;
    endfunction

    function automatic logic [SBA_BUS_W-1:0] size_mask(input logic [1:0] code);
        logic [SBA_BUS_W-1:0] ones;
        ones = '1;
        return ones >> (SBA_BUS_W - 8 * int'(size_bytes(code)));
    endfunction

    function automatic logic [SBA_STRB_W-1:0] lane_strb(input logic [1:0] code,
                                                        input logic [SBA_OFF_W-1:0] off);
        logic [SBA_STRB_W-1:0] ones;
        ones = '1;
        return (~(ones << size_bytes(code))) << off;
    endfunction

endpackage

// File: rtl/sba_addr_inc.sv
module sba_addr_inc
    import sba_pkg::*;
#(
    parameter int WORDS  = SBA_ADDR_WORDS,
    parameter int WORD_W = SBA_WORD_W,
    parameter int STEP_W = SBA_STEP_W
) (
    input  logic [WORDS*WORD_W-1:0] cur,
    input  logic [STEP_W-1:0]       step,
    output logic [WORDS*WORD_W-1:0] nxt
);

    logic [WORDS-1:0] cin;
    assign cin[0] = 1'b0;

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [WORD_W-1:0] addend;
        if (i == 0) begin : g_first
            assign addend = WORD_W'(step);
        end else begin : g_upper
            assign addend = '0;
        end
        if (i < WORDS - 1) begin : g_carry
            logic [WORD_W:0] sum;
            assign sum = {1'b0, cur[i*WORD_W +: WORD_W]} + {1'b0, addend} + (WORD_W+1)'(cin[i]);
            assign nxt[i*WORD_W +: WORD_W] = sum[WORD_W-1:0];
            assign cin[i+1] = sum[WORD_W];
        end else begin : g_top
            assign nxt[i*WORD_W +: WORD_W] = cur[i*WORD_W +: WORD_W] + addend + WORD_W'(cin[i]);
        end
    end

endmodule

// File: rtl/sba_lane.sv
module sba_lane
    import sba_pkg::*;
#(
    parameter int WORD_W = SBA_WORD_W,
    parameter int BUS_W  = SBA_BUS_W,
    parameter int STRB_W = SBA_STRB_W,
    parameter int OFF_W  = SBA_OFF_W
) (
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [WORD_W-1:0] d_lo,
    input  logic [WORD_W-1:0] d_hi,
    input  logic [BUS_W-1:0]  rdata,
    output logic [BUS_W-1:0]  wdata,
    output logic [STRB_W-1:0] strb,
    output logic [WORD_W-1:0] rd_lo,
    output logic [WORD_W-1:0] rd_hi
);

    logic [OFF_W-1:0]   off;
    logic [OFF_W+2:0]   bit_sh;
    logic [BUS_W-1:0]   src;
    logic [BUS_W-1:0]   mask;
    logic [BUS_W-1:0]   picked;

    always_comb begin
        off    = lane_off(addr_lo, size);
        bit_sh = {off, 3'b000};
        mask   = size_mask(size);
        src    = (size == 2'd3) ? {d_hi, d_lo} : {{(BUS_W-WORD_W){1'b0}}, d_lo};
        wdata  = (src & mask) << bit_sh;
        strb   = lane_strb(size, off);
        picked = (rdata >> bit_sh) & mask;
        rd_lo  = picked[WORD_W-1:0];
        rd_hi  = picked[BUS_W-1:WORD_W];
    end

endmodule

// File: rtl/sba_seq.sv
module sba_seq
    import sba_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_valid,
    input  logic size_ok,
    input  logic err_zero,
    input  logic resp_valid,
    output logic busy,
    output logic launch,
    output logic reject,
    output logic done
);

    seq_state_t state_q;
    logic       accept;

    always_comb begin
        accept = (state_q == SEQ_IDLE) && cmd_valid && err_zero;
        launch = accept && size_ok;
        reject = accept && !size_ok;
        done   = (state_q == SEQ_WAIT) && resp_valid;
        busy   = (state_q == SEQ_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
        end else if (launch) begin
            state_q <= SEQ_WAIT;
        end else if (done) begin
            state_q <= SEQ_IDLE;
        end
    end

    // R10: the response ends the busy period on the next cycle
    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R2: a refused size never enters the wait state
    a_r2_reject_idle: assert property (@(posedge clk) disable iff (rst)
        reject |=> !busy);

endmodule

// File: rtl/sba_engine.sv
module sba_engine
    import sba_pkg::*;
#(
    parameter int ADDR_WORDS = SBA_ADDR_WORDS,
    parameter int WORD_W     = SBA_WORD_W,
    parameter int IDX_W      = SBA_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_data,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    output logic              req_valid,
    output logic              req_write,
    output logic [1:0]        req_size,
    output logic [2*WORD_W-1:0] req_addr,
    output logic [2*WORD_W-1:0] req_wdata,
    output logic [2*WORD_W/8-1:0] req_strb,
    input  logic              resp_valid,
    input  logic              resp_fault,
    input  logic [2*WORD_W-1:0] resp_rdata
);

    localparam int BUS_W  = 2 * WORD_W;
    localparam int STRB_W = BUS_W / 8;
    localparam int OFF_W  = $clog2(STRB_W);
    localparam int AFLAT  = ADDR_WORDS * WORD_W;
    localparam int STEP_W = OFF_W + 1;

    ctrl_t              ctrl_q;
    logic [AFLAT-1:0]   addr_q;
    logic [AFLAT-1:0]   addr_next;
    logic [WORD_W-1:0]  data_lo_q;
    logic [WORD_W-1:0]  data_hi_q;
    logic               write_q;

    logic               busy;
    logic               launch;
    logic               reject;
    logic               done;
    logic [WORD_W-1:0]  rd_lo;
    logic [WORD_W-1:0]  rd_hi;
    logic [STEP_W-1:0]  step;

    assign step = STEP_W'(size_bytes(ctrl_q.size[1:0]));

    sba_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .size_ok    (!ctrl_q.size[2]),
        .err_zero   (ctrl_q.err == ERR_NONE),
        .resp_valid (resp_valid),
        .busy       (busy),
        .launch     (launch),
        .reject     (reject),
        .done       (done)
    );

    sba_lane #(
        .WORD_W (WORD_W),
        .BUS_W  (BUS_W),
        .STRB_W (STRB_W),
        .OFF_W  (OFF_W)
    ) u_lane (
        .size    (ctrl_q.size[1:0]),
        .addr_lo (addr_q[OFF_W-1:0]),
        .d_lo    (data_lo_q),
        .d_hi    (data_hi_q),
        .rdata   (resp_rdata),
        .wdata   (req_wdata),
        .strb    (req_strb),
        .rd_lo   (rd_lo),
        .rd_hi   (rd_hi)
    );

    sba_addr_inc #(
        .WORDS  (ADDR_WORDS),
        .WORD_W (WORD_W),
        .STEP_W (STEP_W)
    ) u_inc (
        .cur  (addr_q),
        .step (step),
        .nxt  (addr_next)
    );

    assign req_valid = busy;
    assign req_write = write_q;
    assign req_size  = ctrl_q.size[1:0];
    assign req_addr  = addr_q[BUS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            addr_q    <= '0;
            data_lo_q <= '0;
            data_hi_q <= '0;
            write_q   <= 1'b0;
        end else begin
            if (reg_wr_en && !busy) begin
                if (reg_idx == IDX_CTRL) begin
                    ctrl_q.size    <= reg_wdata[2:0];
                    ctrl_q.autoinc <= reg_wdata[3];
                    ctrl_q.err     <= ctrl_q.err & ~reg_wdata[6:4];
                end
                for (int k = 0; k < ADDR_WORDS; k++) begin
                    if (reg_idx == IDX_W'(IDX_ADDR_BASE + k)) begin
                        addr_q[k*WORD_W +: WORD_W] <= reg_wdata;
                    end
                end
                if (reg_idx == IDX_W'(IDX_ADDR_BASE + ADDR_WORDS)) begin
                    data_lo_q <= reg_wdata;
                end
                if (reg_idx == IDX_W'(IDX_ADDR_BASE + ADDR_WORDS + 1)) begin
                    data_hi_q <= reg_wdata;
                end
            end
            if (launch) begin
                write_q <= cmd_write;
            end
            if (reject) begin
                ctrl_q.err <= ERR_SIZE;
            end
            if (done) begin
                if (resp_fault) begin
                    ctrl_q.err <= ERR_BUS;
                end else begin
                    if (!write_q) begin
                        data_lo_q <= rd_lo;
                        if (ctrl_q.size[1:0] == 2'd3) begin
                            data_hi_q <= rd_hi;
                        end
                    end
                    if (ctrl_q.autoinc) begin
                        addr_q <= addr_next;
                    end
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx == IDX_CTRL) begin
            rd_data = {{(WORD_W-8){1'b0}}, busy, ctrl_q};
        end
        for (int k = 0; k < ADDR_WORDS; k++) begin
            if (rd_idx == IDX_W'(IDX_ADDR_BASE + k)) begin
                rd_data = addr_q[k*WORD_W +: WORD_W];
            end
        end
        if (rd_idx == IDX_W'(IDX_ADDR_BASE + ADDR_WORDS)) begin
            rd_data = data_lo_q;
        end
        if (rd_idx == IDX_W'(IDX_ADDR_BASE + ADDR_WORDS + 1)) begin
            rd_data = data_hi_q;
        end
    end

    // R10: a pending request holds still until its response
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !resp_valid) |=> (req_valid && $stable(req_addr) && $stable(req_wdata)));

    // R1: byte enable count follows the size code
    a_r1_strb_count: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ($countones(req_strb) == (1 << req_size)));

    // R2: an unsupported size issues nothing and reports code 3
    a_r2_bad_size: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !req_valid && ctrl_q.err == ERR_NONE && ctrl_q.size[2])
        |=> (!req_valid && ctrl_q.err == ERR_SIZE));

    // R4: a nonzero error blocks new requests
    a_r4_err_blocks: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.err != ERR_NONE && !req_valid) |=> !req_valid);

    // R3: a faulting response leaves code 2 and frees the engine
    a_r3_fault_code: assert property (@(posedge clk) disable iff (rst)
        (req_valid && resp_valid && resp_fault) |=> (ctrl_q.err == ERR_BUS && !req_valid));

    // R5: no address movement when autoincrement is off
    a_r5_no_step: assert property (@(posedge clk) disable iff (rst)
        (req_valid && resp_valid && !ctrl_q.autoinc) |=> $stable(addr_q));

    // R6: a good response with autoincrement moves the whole address by the access size
    a_r6_wide_step: assert property (@(posedge clk) disable iff (rst)
        (req_valid && resp_valid && !resp_fault && ctrl_q.autoinc)
        |=> (addr_q == $past(addr_q) + AFLAT'($past(step))));

endmodule

// File: tb/sba_engine_tb.sv
`timescale 1ns/1ps
module sba_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        cmd_valid = 1'b0;
    logic        cmd_write = 1'b0;
    logic        req_valid;
    logic        req_write;
    logic [1:0]  req_size;
    logic [63:0] req_addr;
    logic [63:0] req_wdata;
    logic [7:0]  req_strb;
    logic        resp_valid = 1'b0;
    logic        resp_fault = 1'b0;
    logic [63:0] resp_rdata = '0;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    logic [7:0]  bus_mem [0:63];
    logic [7:0]  ref_mem [0:63];
    int          req_count = 0;
    int          lat_cnt = 0;
    int          lat_force = 0;
    logic [7:0]  last_strb;
    logic [1:0]  last_size;
    logic [63:0] last_addr;

    localparam logic [31:0] BAD_HI = 32'hBAD0_0000;

    always #2.5 clk = ~clk;

    sba_engine u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_wr_en  (reg_wr_en),
        .reg_idx    (reg_idx),
        .reg_wdata  (reg_wdata),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_strb   (req_strb),
        .resp_valid (resp_valid),
        .resp_fault (resp_fault),
        .resp_rdata (resp_rdata)
    );

    // bus model: responds after a latency, memory indexed by address bits [5:0]
    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            resp_valid = 1'b0;
            resp_fault = 1'b0;
            lat_cnt = 0;
        end else if (resp_valid) begin
            resp_valid = 1'b0;
            resp_fault = 1'b0;
        end else if (req_valid) begin
            if (lat_cnt >= ((lat_force != 0) ? lat_force : 1 + (req_count % 3))) begin
                lat_cnt = 0;
                req_count++;
                last_strb = req_strb;
                last_size = req_size;
                last_addr = req_addr;
                resp_fault = (req_addr[63:32] == BAD_HI);
                for (int b = 0; b < 8; b++) begin
                    resp_rdata[8*b +: 8] = bus_mem[{req_addr[5:3], 3'(b)}];
                    if (req_write && !resp_fault && req_strb[b])
                        bus_mem[{req_addr[5:3], 3'(b)}] = req_wdata[8*b +: 8];
                end
                resp_valid = 1'b1;
            end else begin
                lat_cnt++;
            end
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_idx = 3'(idx);
        reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        @(negedge clk);
        rd_idx = 3'(idx);
        #1;
        v = rd_data;
    endtask

    task automatic cfg(input int size, input bit inc);
        wr(0, {24'h0, 1'b0, 3'b000, inc, 3'(size)});
    endtask

    task automatic go(input bit w);
        logic [31:0] v;
        bit idle;
        idle = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_write = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int t = 0; t < 60; t++) begin
            rd(0, v);
            if (!v[7]) begin
                idle = 1'b1;
                break;
            end
        end
        if (!idle) check("R10 busy never cleared", 64'd1, 64'd0);
    endtask

    function automatic logic [63:0] ref_read(input logic [5:0] a, input int s);
        logic [63:0] r;
        int n;
        logic [2:0] off;
        n = 1 << s;
        off = a[2:0] & ~3'(n - 1);
        r = '0;
        for (int i = 0; i < n; i++) r[8*i +: 8] = ref_mem[{a[5:3], 3'(off + 3'(i))}];
        return r;
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected=<100000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] d0;
        logic [31:0] d1;
        logic [31:0] a0;
        logic [63:0] e;
        int n;
        int cnt0;

        for (int i = 0; i < 64; i++) begin
            bus_mem[i] = 8'(i * 37 + 5);
            ref_mem[i] = 8'(i * 37 + 5);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        for (int i = 0; i < 7; i++) begin
            rd(i, v);
            check($sformatf("R11 reg %0d after reset", i), 64'(v), 64'd0);
        end
        check("R11 req_valid after reset", 64'(req_valid), 64'd0);

        // R1 R7 R9: write sweep over every size and aligned offset
        wr(2, 32'h0000_1234);
        for (int s = 0; s < 4; s++) begin
            n = 1 << s;
            cfg(s, 1'b0);
            for (int off = 0; off < 8; off += n) begin
                a0 = {26'h0, 3'((s + off) % 8), 3'(off)};
                d0 = 32'hA500_0000 ^ 32'(s << 12) ^ 32'(off * 33 + 7);
                d1 = ~d0 ^ 32'(off);
                wr(1, a0);
                wr(5, d0);
                wr(6, d1);
                go(1'b1);
                check("R1 strobe", 64'(last_strb), 64'(((1 << n) - 1) << off));
                check("R1 size", 64'(last_size), 64'(s));
                check("R7 address", last_addr, {32'h0000_1234, a0});
                rd(1, v);
                check("R5 address unchanged with autoincrement off", 64'(v), 64'(a0));
                e = (s == 3) ? {d1, d0} : 64'(d0);
                for (int i = 0; i < n; i++) ref_mem[{a0[5:3], 3'(off + i)}] = e[8*i +: 8];
            end
        end

        // R8: read sweep; data word 1 must keep its value on narrow reads
        for (int s = 0; s < 4; s++) begin
            n = 1 << s;
            cfg(s, 1'b0);
            for (int off = 0; off < 8; off += n) begin
                a0 = {26'h0, 3'((s + 3 * off + 1) % 8), 3'(off)};
                wr(1, a0);
                wr(6, 32'hCAFE_F00D);
                go(1'b0);
                e = ref_read(a0[5:0], s);
                rd(5, v);
                check($sformatf("R8 data word 0 size %0d off %0d", s, off), 64'(v), 64'(e[31:0]));
                rd(6, v);
                check($sformatf("R8 data word 1 size %0d off %0d", s, off), 64'(v),
                      (s == 3) ? 64'(e[63:32]) : 64'h0000_0000_CAFE_F00D);
            end
        end

        // R9: full-word readback of all memory checks every byte written
        cfg(3, 1'b0);
        for (int w = 0; w < 8; w++) begin
            wr(1, 32'(w * 8));
            go(1'b0);
            e = ref_read(6'(w * 8), 3);
            rd(5, v);
            check($sformatf("R9 memory word %0d low", w), 64'(v), 64'(e[31:0]));
            rd(6, v);
            check($sformatf("R9 memory word %0d high", w), 64'(v), 64'(e[63:32]));
        end

        // R5: autoincrement steps by the access size
        for (int s = 0; s < 4; s++) begin
            n = 1 << s;
            cfg(s, 1'b1);
            wr(1, 32'h10);
            wr(2, 32'h0);
            for (int k = 0; k < 4; k++) begin
                go(1'b0);
                rd(1, v);
                check($sformatf("R5 step size %0d access %0d", s, k), 64'(v), 64'(32'h10 + (k + 1) * n));
            end
        end
        cfg(0, 1'b1);
        wr(1, 32'h7);
        go(1'b1);
        rd(1, v);
        check("R5 write also steps", 64'(v), 64'h8);
        ref_mem[7] = 8'(ref_mem[7]);

        // R6: carries across words
        cfg(2, 1'b1);
        wr(1, 32'hFFFF_FFFC);
        wr(2, 32'h0);
        go(1'b0);
        rd(1, v);
        check("R6 word 0 wrap", 64'(v), 64'h0);
        rd(2, v);
        check("R6 carry into word 1", 64'(v), 64'h1);
        cfg(3, 1'b1);
        wr(1, 32'hFFFF_FFF8);
        wr(2, 32'hFFFF_FFFF);
        wr(3, 32'hFFFF_FFFF);
        wr(4, 32'h5);
        go(1'b0);
        for (int i = 1; i < 4; i++) begin
            rd(i, v);
            check($sformatf("R6 word %0d wraps", i - 1), 64'(v), 64'h0);
        end
        rd(4, v);
        check("R6 carry into word 3", 64'(v), 64'h6);

        // R3: fault sets code 2, data and address unchanged
        cfg(2, 1'b1);
        wr(1, 32'h20);
        wr(2, BAD_HI);
        wr(5, 32'h1111_1111);
        go(1'b0);
        rd(0, v);
        check("R3 error code after fault", 64'(v[6:4]), 64'd2);
        rd(5, v);
        check("R3 data unchanged after fault", 64'(v), 64'h1111_1111);
        rd(1, v);
        check("R3 address unchanged after fault", 64'(v), 64'h20);

        // R4: commands refused while the error is set; write-one-to-clear
        cnt0 = req_count;
        go(1'b0);
        check("R4 no request while error set", 64'(req_count), 64'(cnt0));
        wr(0, {24'h0, 1'b0, 3'b001, 1'b1, 3'd2});
        rd(0, v);
        check("R4 unmatched clear bit keeps error", 64'(v[6:4]), 64'd2);
        wr(0, {24'h0, 1'b0, 3'b010, 1'b1, 3'd2});
        rd(0, v);
        check("R4 matched clear bit clears error", 64'(v[6:4]), 64'd0);
        wr(2, 32'h0);
        go(1'b0);
        check("R4 request resumes after clear", 64'(req_count), 64'(cnt0 + 1));

        // R2: unsupported size codes
        for (int s = 4; s < 8; s++) begin
            cfg(s, 1'b1);
            cnt0 = req_count;
            wr(1, 32'h8);
            go(1'b1);
            check($sformatf("R2 no request for size %0d", s), 64'(req_count), 64'(cnt0));
            rd(0, v);
            check($sformatf("R2 error code for size %0d", s), 64'(v[6:4]), 64'd3);
            rd(1, v);
            check($sformatf("R2 address unchanged for size %0d", s), 64'(v), 64'h8);
            wr(0, {24'h0, 1'b0, 3'b111, 1'b0, 3'd0});
        end

        // R10: busy flag and writes ignored while busy
        cfg(2, 1'b0);
        wr(1, 32'h8);
        lat_force = 8;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_write = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        rd(0, v);
        check("R10 busy bit during access", 64'(v[7]), 64'd1);
        wr(1, 32'hDEAD_BEEC);
        check("R10 request still pending", 64'(req_valid), 64'd1);
        lat_force = 0;
        go(1'b0);
        rd(1, v);
        check("R10 write during busy ignored", 64'(v), 64'h8);
        rd(0, v);
        check("R10 busy clear after response", 64'(v[7]), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule